// File: doc/BRIEF.md
# Sixteen-Bit ALU with Registered Status

This block is the arithmetic stage of a small accumulator datapath. A combinational core takes two operands and a three-bit operation code and produces a result word. It also produces two flags: a zero flag, and an exception flag that marks signed overflow or underflow of an arithmetic operation. The result and both flags are visible at once on the combinational outputs.

A status register sits behind the core. On a rising clock edge it captures the result and both flags together, but only when the load-status strobe is high. Otherwise it keeps what it holds. An active-low asynchronous reset clears it.

The surrounding controller selects the operation and raises the strobe in the cycle whose outcome it wants to keep. A parameter chooses how the adder is built: a plain adder operator or an explicit ripple-carry chain. Both variants behave the same.

Top module: `alu_status_unit`

## Requirements
- R1: The operation code selects the result as follows: 000 passes A, 001 is A+B, 010 is A-B, 011 is A AND B, 100 is A XOR B, 101 passes B, 110 is A+1, and 111 is A OR B. Arithmetic wraps modulo 2^16. Every code has a defined operation. Out of reset, no bit of A, B or the code may be X or Z; this is flagged in simulation only.
- R2: The zero flag is 1 exactly when the 16-bit result is 0.
- R3: For code 001, the exception flag is 1 exactly when the signed sum of A and B lies outside -32768..32767.
- R4: For code 010, the exception flag is 1 exactly when the signed difference A-B lies outside -32768..32767.
- R5: For code 110, the exception flag is 1 exactly when A is 0x7FFF.
- R6: For codes 000, 011, 100, 101 and 111, the exception flag is always 0.
- R7: On a rising clock edge with load-status high, the status outputs take the result, exception and zero values present before that edge.
- R8: On a rising clock edge with load-status low, the status outputs keep their values.
- R9: While reset is low, the status outputs are all 0. Reset takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| op_sel | input | 3 | Operation code |
| load_stat | input | 1 | Capture strobe for the status register |
| alu_result | output | 16 | Combinational result |
| alu_zero | output | 1 | Combinational zero flag |
| alu_exc | output | 1 | Combinational exception flag |
| stat_result | output | 16 | Registered result |
| stat_exc | output | 1 | Registered exception flag |
| stat_zero | output | 1 | Registered zero flag |

## Verification
A wrong carry path or a wrong sign rule in the core shows up at once on the combinational outputs, in the same cycle the operands are driven. Corner operands are chosen so that the MSB carry and the sign of the result are exercised. A status register that fails to capture, or captures when it should not, shows up in the registered outputs. That difference appears one edge after the strobe and stays until the next load. Comparing every cycle therefore catches both a missed load and a spurious one. A slow or missing reset shows up when reset is asserted between edges: the status outputs must read zero before any further edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      OP_PASS_A = 3'b000,
      OP_ADD    = 3'b001,
      OP_SUB    = 3'b010,
      OP_AND    = 3'b011,
      OP_XOR    = 3'b100,
      OP_PASS_B = 3'b101,
      OP_INC    = 3'b110,
      OP_OR     = 3'b111
   } alu_op_e;

   function automatic logic op_is_arith(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
   endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic [WIDTH-1:0] add_x,
   input  logic [WIDTH-1:0] add_y,
   input  logic             add_cin,
   output logic [WIDTH-1:0] add_sum
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_adder: WIDTH must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("alu_adder: ADDER_STYLE must be 0 or 1");
   end

   if (ADDER_STYLE == 0) begin : g_operator
      always_comb begin
         add_sum = add_x + add_y + {{(WIDTH-1){1'b0}}, add_cin};
      end
   end else begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = add_cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign add_sum[i]   = add_x[i] ^ add_y[i] ^ carry[i];
         assign carry[i+1]   = (add_x[i] & add_y[i]) |
                               (carry[i] & (add_x[i] ^ add_y[i]));
      end
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic [WIDTH-1:0] core_a,
   input  logic [WIDTH-1:0] core_b,
   input  logic [2:0]       core_op,
   output logic [WIDTH-1:0] core_result,
   output logic             core_exc,
   output logic             core_zero
);

   localparam int MSB = WIDTH - 1;

   alu_op_e          op_dec;
   logic [WIDTH-1:0] y_eff;
   logic             cin_eff;
   logic [WIDTH-1:0] sum;

   assign op_dec = alu_op_e'(core_op);

   always_comb begin
      y_eff   = core_b;
      cin_eff = 1'b0;
      if (op_dec == OP_SUB) begin
         y_eff   = ~core_b;
         cin_eff = 1'b1;
      end else if (op_dec == OP_INC) begin
         y_eff   = '0;
         cin_eff = 1'b1;
      end
   end

   alu_adder #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_adder (
      .add_x   (core_a),
      .add_y   (y_eff),
      .add_cin (cin_eff),
      .add_sum (sum)
   );

   always_comb begin
      core_result = '0;
      core_exc    = 1'b0;
      unique case (op_dec)
         OP_PASS_A: core_result = core_a;
         OP_ADD: begin
            core_result = sum;
            core_exc    = (core_a[MSB] == core_b[MSB]) && (sum[MSB] != core_a[MSB]);
         end
         OP_SUB: begin
            core_result = sum;
            core_exc    = (core_a[MSB] != core_b[MSB]) && (sum[MSB] != core_a[MSB]);
         end
         OP_AND:    core_result = core_a & core_b;
         OP_XOR:    core_result = core_a ^ core_b;
         OP_PASS_B: core_result = core_b;
         OP_INC: begin
            core_result = sum;
            core_exc    = !core_a[MSB] && sum[MSB];
         end
         OP_OR:     core_result = core_a | core_b;
      endcase
   end

   assign core_zero = ~|core_result;

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [WIDTH-1:0] cap_result,
   input  logic             cap_exc,
   input  logic             cap_zero,
   output logic [WIDTH-1:0] held_result,
   output logic             held_exc,
   output logic             held_zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_result <= '0;
         held_exc    <= 1'b0;
         held_zero   <= 1'b0;
      end else if (cap_en) begin
         held_result <= cap_result;
         held_exc    <= cap_exc;
         held_zero   <= cap_zero;
      end
   end

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(held_result) && $stable(held_exc) && $stable(held_zero));

   // R7
   capture_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (held_result == $past(cap_result)) && (held_exc == $past(cap_exc))
                 && (held_zero == $past(cap_zero)));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import alu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int OP_W        = 3,
   parameter int ADDER_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [OP_W-1:0]   op_sel,
   input  logic              load_stat,
   output logic [DATA_W-1:0] alu_result,
   output logic              alu_zero,
   output logic              alu_exc,
   output logic [DATA_W-1:0] stat_result,
   output logic              stat_exc,
   output logic              stat_zero
);

   if (OP_W != 3) begin : g_bad_op_w
      $error("alu_status_unit: OP_W must be 3");
   end

   alu_core #(
      .WIDTH       (DATA_W),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_core (
      .core_a      (opnd_a),
      .core_b      (opnd_b),
      .core_op     (op_sel[2:0]),
      .core_result (alu_result),
      .core_exc    (alu_exc),
      .core_zero   (alu_zero)
   );

   alu_status_reg #(
      .WIDTH (DATA_W)
   ) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en      (load_stat),
      .cap_result  (alu_result),
      .cap_exc     (alu_exc),
      .cap_zero    (alu_zero),
      .held_result (stat_result),
      .held_exc    (stat_exc),
      .held_zero   (stat_zero)
   );

   // R1
   inputs_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({opnd_a, opnd_b, op_sel, load_stat}));

   // R6
   exc_only_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_exc |-> op_is_arith(alu_op_e'(op_sel[2:0])));

   // R2
   held_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_zero |-> (stat_result == '0));

   // R2
   comb_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_zero |-> (alu_result == '0));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (stat_result == '0) && !stat_exc && !stat_zero);

endmodule

// File: tb/alu_status_unit_bench.sv
module alu_status_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] a, b;
   logic [2:0]  op;
   logic        ld;
   logic [15:0] res, s_res;
   logic        zro, exc, s_exc, s_zro;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [15:0] es_res;
   logic        es_exc, es_zro;
   logic        last_ld;

   always #5 clk = ~clk;

   alu_status_unit u_alu_status_unit (
      .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .op_sel(op), .load_stat(ld),
      .alu_result(res), .alu_zero(zro), .alu_exc(exc),
      .stat_result(s_res), .stat_exc(s_exc), .stat_zero(s_zro));

   task automatic model(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o,
                        output logic [15:0] r, output logic ex);
      int sx, sy, s;
      sx = int'($signed(x));
      sy = int'($signed(y));
      ex = 1'b0;
      s  = 0;
      case (o)
         3'd0: r = x;
         3'd1: begin s = sx + sy; r = s[15:0]; ex = (s > 32767) || (s < -32768); end
         3'd2: begin s = sx - sy; r = s[15:0]; ex = (s > 32767) || (s < -32768); end
         3'd3: r = x & y;
         3'd4: r = x ^ y;
         3'd5: r = y;
         3'd6: begin s = sx + 1; r = s[15:0]; ex = (s > 32767); end
         default: r = x | y;
      endcase
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%h exp=%h (a=%h b=%h op=%0d)", tag, act, expv, a, b, op);
      end
   endtask

   task automatic compare();
      logic [15:0] r;
      logic        ex;
      string       etag;
      model(a, b, op, r, ex);
      chk("R1 result", res, r);
      chk("R2 zero", {15'd0, zro}, {15'd0, (r == 16'd0)});
      case (op)
         3'd1:    etag = "R3 add exc";
         3'd2:    etag = "R4 sub exc";
         3'd6:    etag = "R5 inc exc";
         default: etag = "R6 logic exc";
      endcase
      chk(etag, {15'd0, exc}, {15'd0, ex});
      if (last_ld) begin
         chk("R7 stat result", s_res, es_res);
         chk("R7 stat exc", {15'd0, s_exc}, {15'd0, es_exc});
         chk("R7 stat zero", {15'd0, s_zro}, {15'd0, es_zro});
      end else begin
         chk("R8 stat result", s_res, es_res);
         chk("R8 stat exc", {15'd0, s_exc}, {15'd0, es_exc});
         chk("R8 stat zero", {15'd0, s_zro}, {15'd0, es_zro});
      end
   endtask

   task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [2:0] o,
                        input logic l);
      logic [15:0] r;
      logic        ex;
      @(negedge clk);
      compare();
      a  = x;
      b  = y;
      op = o;
      ld = l;
      @(posedge clk);
      if (l) begin
         model(x, y, o, r, ex);
         es_res = r;
         es_exc = ex;
         es_zro = (r == 16'd0);
      end
      last_ld = l;
   endtask

   task automatic chk_reset(input string tag);
      chk(tag, s_res, 16'd0);
      chk(tag, {14'd0, s_exc, s_zro}, 16'd0);
   endtask

   initial begin
      rst_n = 1'b0;
      a = 16'h0005; b = 16'h0000; op = 3'd0; ld = 1'b1;
      es_res = '0; es_exc = 1'b0; es_zro = 1'b0; last_ld = 1'b0;
      repeat (3) @(negedge clk);
      chk_reset("R9 reset state");
      ld = 1'b0;
      rst_n = 1'b1;

      // R3 add corners
      apply(16'h7FFF, 16'h0001, 3'd1, 1'b1);
      apply(16'h8000, 16'hFFFF, 3'd1, 1'b1);
      apply(16'hFFFF, 16'h0001, 3'd1, 1'b1);
      apply(16'h4000, 16'h3FFF, 3'd1, 1'b0);
      // R4 sub corners
      apply(16'h8000, 16'h0001, 3'd2, 1'b1);
      apply(16'h7FFF, 16'hFFFF, 3'd2, 1'b1);
      apply(16'h0000, 16'h8000, 3'd2, 1'b1);
      apply(16'h1234, 16'h1234, 3'd2, 1'b1);
      // R5 inc corners
      apply(16'h7FFF, 16'hAAAA, 3'd6, 1'b1);
      apply(16'hFFFF, 16'h0000, 3'd6, 1'b1);
      apply(16'h7FFE, 16'h0000, 3'd6, 1'b0);
      // R6 logic and pass ops with sign bits set
      apply(16'h8000, 16'h8000, 3'd0, 1'b1);
      apply(16'hF0F0, 16'h0F0F, 3'd3, 1'b1);
      apply(16'hBEEF, 16'hBEEF, 3'd4, 1'b1);
      apply(16'h0000, 16'h8001, 3'd5, 1'b1);
      apply(16'h8000, 16'h7FFF, 3'd7, 1'b1);
      // R8 hold while strobe low
      apply(16'h0001, 16'h0002, 3'd1, 1'b0);
      apply(16'h0000, 16'h0000, 3'd7, 1'b0);

      // R9 asynchronous reset between edges
      apply(16'h7FFF, 16'h7FFF, 3'd1, 1'b1);
      #2 rst_n = 1'b0;
      #1 chk_reset("R9 async reset");
      es_res = '0; es_exc = 1'b0; es_zro = 1'b0;
      ld = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      last_ld = 1'b0;

      for (int i = 0; i < 3000; i++) begin
         logic [15:0] rx, ry;
         rx = 16'($urandom);
         ry = 16'($urandom);
         if (i % 7 == 0) rx = {rx[15], 15'h7FFF};
         if (i % 11 == 0) ry = rx;
         apply(rx, ry, 3'($urandom), 1'($urandom));
      end
      @(negedge clk);
      compare();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule